// File: doc/BRIEF.md
# Multi-Error Correction Result Applier

This block sits behind a syndrome and root-search engine that corrects up to four byte errors per 512-byte sector. Once the engine has run, this block turns its results into fixes on the sector data. The sector itself sits in a single-port byte RAM outside the block. After a start pulse, the block first looks at the sector's stored check bytes and syndrome words. If the sector is erased, or the syndrome shows nothing to fix, it finishes at once and reports clean.

Otherwise the block polls the engine's 4-bit correction state until it shows a final code. A fail code ends the operation as uncorrectable, and no data is touched. A completion code makes the block latch the error count and the packed location and value words. It then walks the error slots in order. For each slot it turns the reported location into a sector byte offset. When the offset lies inside the sector, it XORs the error value into that byte with a two-cycle read-modify-write.

The outcome comes back as a result code and a count of fixes that were applied, along with a one-cycle done pulse.

FSM states and transitions:
- `S_IDLE` -> `S_FINISH` on start when the sector is erased or the syndrome is all zero.
- `S_IDLE` -> `S_WAIT` on start otherwise.
- `S_WAIT` holds while the state code is not final.
- `S_WAIT` -> `S_FINISH` on a clean or fail code.
- `S_WAIT` -> `S_READ` on a completion code.
- `S_READ` -> `S_WRITE` when the current slot is in range.
- `S_READ` -> `S_READ` when the slot is out of range, skipping it.
- `S_READ` -> `S_FINISH` when the last slot is out of range.
- `S_WRITE` -> `S_READ` for the next slot.
- `S_WRITE` -> `S_FINISH` after the last slot.
- `S_FINISH` -> `S_IDLE`.

Top module: `ecc_fix_applier`

## Requirements
- R1: After reset, busy, done, ram_we, result and fix_count are all 0.
- R2: When a start is accepted and all 80 bits of stored_ecc are 1 (every check byte reads 0xFF), done rises in the cycle after start with result 0 (clean) and count 0. No RAM write takes place, and corr_state is not consulted. This test takes priority over the syndrome test.
- R3: When a start is accepted and all 128 syndrome bits are 0, done rises in the cycle after start with result 0 and count 0, and no RAM write takes place.
- R4: Otherwise the block waits with busy=1 and done=0 for as long as corr_state is not 0, 1, 2, 3 or 5.
- R5: A corr_state of 0 or 5 ends the wait with result 0, count 0, and no RAM write.
- R6: A corr_state of 1 ends the wait with result 2 (uncorrectable), count 0, and no RAM write.
- R7: A corr_state of 2 or 3 applies err_cnt+1 errors. Error k takes its location from loc_words bits [32*(k/2)+16*(k%2) +: 10] and its value from val_words bits [32*(k/2)+16*(k%2) +: 8]. The upper bits of each 16-bit lane are ignored, and slots beyond err_cnt are not used.
- R8: The byte offset of an error is 519 minus its 10-bit location. The error is applied only when that offset lies in 0..511, that is, when the location is in 8..519. Any other location is skipped and not counted.
- R9: Each applied error reads the addressed byte and writes back the byte XOR the value in the next cycle, at the same address. The RAM has one cycle of read latency. Errors are applied in slot order, so two errors on the same byte both take effect.
- R10: A completion ends with one done pulse carrying result 1 and fix_count equal to the number of errors applied (0 to 4). result and fix_count hold their values until the next operation ends.
- R11: A start that arrives while busy is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| stored_ecc | input | 80 | The ten check bytes read from the sector's spare area |
| syndrome | input | 128 | The four syndrome words from the engine |
| corr_state | input | 4 | Live correction state code from the engine |
| err_cnt | input | 2 | Number of errors minus one |
| loc_words | input | 64 | Two words, each packing two error locations (16-bit lanes) |
| val_words | input | 64 | Two words, each packing two error values (16-bit lanes) |
| ram_addr | output | 9 | Sector RAM byte address |
| ram_we | output | 1 | Sector RAM write enable |
| ram_wdata | output | 8 | Sector RAM write data |
| ram_rdata | input | 8 | Sector RAM read data, one cycle after the address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| result | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| fix_count | output | 3 | Number of errors applied |

## Verification
The hardest behaviour to reach is a wait that lasts while the state code changes under the block. The stimulus holds corr_state on each non-final code in turn and confirms that nothing finishes. During that wait it also issues a second start with an erased check-byte pattern, which must be ignored. Other cases need their location words shaped with care:
- locations just outside 8..519, and locations in slots past err_cnt;
- nonzero upper lane bits;
- two errors on one byte, where the second read must see the first write.

After each operation, the bench compares every byte of the sector against its own model and counts the RAM writes.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_READ,
        S_WRITE,
        S_FINISH
    } fix_state_t;

    typedef enum logic [1:0] {
        RES_CLEAN = 2'd0,
        RES_FIXED = 2'd1,
        RES_FAIL  = 2'd2
    } fix_result_t;

    typedef enum logic [1:0] {
        CLS_PENDING,
        CLS_CLEAN,
        CLS_FAIL,
        CLS_APPLY
    } state_class_t;

    localparam logic [3:0] CODE_NO_ERR      = 4'd0;
    localparam logic [3:0] CODE_TOO_MANY    = 4'd1;
    localparam logic [3:0] CODE_DONE_PARITY = 4'd2;
    localparam logic [3:0] CODE_DONE        = 4'd3;
    localparam logic [3:0] CODE_ALIAS_CLEAN = 4'd5;

endpackage

// File: rtl/ecc_fix_classify.sv
module ecc_fix_classify
    import ecc_fix_pkg::*;
(
    input  logic [3:0]   raw_state,
    output state_class_t cls
);

    always_comb begin
        case (raw_state)
            CODE_NO_ERR,
            CODE_ALIAS_CLEAN: cls = CLS_CLEAN;
            CODE_TOO_MANY:    cls = CLS_FAIL;
            CODE_DONE_PARITY,
            CODE_DONE:        cls = CLS_APPLY;
            default:          cls = CLS_PENDING;
        endcase
    end

endmodule

// File: rtl/ecc_fix_screen.sv
module ecc_fix_screen #(
    parameter int CHECK_BYTES = 10,
    parameter int SYN_WORDS   = 4
) (
    input  logic [8*CHECK_BYTES-1:0] stored_ecc,
    input  logic [32*SYN_WORDS-1:0]  syndrome,
    output logic                     erased,
    output logic                     syn_zero
);

    assign erased   = &stored_ecc;
    assign syn_zero = ~|syndrome;

endmodule

// File: rtl/ecc_fix_locator.sv
module ecc_fix_locator #(
    parameter int MAX_ERR      = 4,
    parameter int LOC_W        = 10,
    parameter int VAL_W        = 8,
    parameter int SECTOR_BYTES = 512,
    parameter int ADDR_BIAS    = 519,
    localparam int AW          = $clog2(SECTOR_BYTES),
    localparam int PAIR_WORDS  = (MAX_ERR + 1) / 2
) (
    input  logic [32*PAIR_WORDS-1:0]        loc_words,
    input  logic [32*PAIR_WORDS-1:0]        val_words,
    output logic [MAX_ERR-1:0][AW-1:0]      offs,
    output logic [MAX_ERR-1:0][VAL_W-1:0]   vals,
    output logic [MAX_ERR-1:0]              in_range
);

    localparam int DW = LOC_W + 2;

    for (genvar g = 0; g < MAX_ERR; g++) begin : g_lane
        localparam int BASE = 32 * (g / 2) + 16 * (g % 2);
        logic [LOC_W-1:0] loc;
        logic [DW-1:0]    diff;
        logic             unused_lane;

        assign loc         = loc_words[BASE +: LOC_W];
        assign diff        = DW'(ADDR_BIAS) - DW'(loc);
        assign offs[g]     = diff[AW-1:0];
        assign vals[g]     = val_words[BASE +: VAL_W];
        assign in_range[g] = !diff[DW-1] && (diff < DW'(SECTOR_BYTES));
        assign unused_lane = ^{loc_words[BASE+LOC_W +: (16-LOC_W)],
                               val_words[BASE+VAL_W +: (16-VAL_W)]};
    end

    if ((MAX_ERR % 2) != 0) begin : g_odd
        logic unused_tail;
        assign unused_tail = ^{loc_words[32*PAIR_WORDS-1 -: 16],
                               val_words[32*PAIR_WORDS-1 -: 16]};
    end

endmodule

// File: rtl/ecc_fix_applier.sv
module ecc_fix_applier
    import ecc_fix_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int MAX_ERR      = 4,
    parameter int LOC_W        = 10,
    parameter int VAL_W        = 8,
    parameter int CHECK_BYTES  = 10,
    parameter int SYN_WORDS    = 4,
    localparam int AW          = $clog2(SECTOR_BYTES),
    localparam int CNT_W       = $clog2(MAX_ERR),
    localparam int FIXC_W      = $clog2(MAX_ERR + 1),
    localparam int PAIR_WORDS  = (MAX_ERR + 1) / 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [8*CHECK_BYTES-1:0]   stored_ecc,
    input  logic [32*SYN_WORDS-1:0]    syndrome,
    input  logic [3:0]                 corr_state,
    input  logic [CNT_W-1:0]           err_cnt,
    input  logic [32*PAIR_WORDS-1:0]   loc_words,
    input  logic [32*PAIR_WORDS-1:0]   val_words,
    output logic [AW-1:0]              ram_addr,
    output logic                       ram_we,
    output logic [VAL_W-1:0]           ram_wdata,
    input  logic [VAL_W-1:0]           ram_rdata,
    output logic                       busy,
    output logic                       done,
    output logic [1:0]                 result,
    output logic [FIXC_W-1:0]          fix_count
);

    localparam int ADDR_BIAS = SECTOR_BYTES + 7;

    fix_state_t                    state, nxt;
    state_class_t                  cls;
    logic                          erased, syn_zero;
    logic [CNT_W-1:0]              idx, last_idx;
    logic [32*PAIR_WORDS-1:0]      loc_q, val_q;
    logic [FIXC_W-1:0]             applied;
    fix_result_t                   result_q;
    logic [FIXC_W-1:0]             count_q;
    logic [MAX_ERR-1:0][AW-1:0]    offs;
    logic [MAX_ERR-1:0][VAL_W-1:0] vals;
    logic [MAX_ERR-1:0]            in_range;
    logic                          is_last;

    ecc_fix_classify i_classify (
        .raw_state (corr_state),
        .cls       (cls)
    );

    ecc_fix_screen #(
        .CHECK_BYTES (CHECK_BYTES),
        .SYN_WORDS   (SYN_WORDS)
    ) i_screen (
        .stored_ecc (stored_ecc),
        .syndrome   (syndrome),
        .erased     (erased),
        .syn_zero   (syn_zero)
    );

    ecc_fix_locator #(
        .MAX_ERR      (MAX_ERR),
        .LOC_W        (LOC_W),
        .VAL_W        (VAL_W),
        .SECTOR_BYTES (SECTOR_BYTES),
        .ADDR_BIAS    (ADDR_BIAS)
    ) i_locator (
        .loc_words (loc_q),
        .val_words (val_q),
        .offs      (offs),
        .vals      (vals),
        .in_range  (in_range)
    );

    assign is_last = (idx == last_idx);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start) nxt = (erased || syn_zero) ? S_FINISH : S_WAIT;
            end
            S_WAIT: begin
                unique case (cls)
                    CLS_CLEAN,
                    CLS_FAIL:    nxt = S_FINISH;
                    CLS_APPLY:   nxt = S_READ;
                    CLS_PENDING: nxt = S_WAIT;
                    default:     nxt = S_WAIT;
                endcase
            end
            S_READ: begin
                if (in_range[idx]) nxt = S_WRITE;
                else if (is_last)  nxt = S_FINISH;
            end
            S_WRITE:  nxt = is_last ? S_FINISH : S_READ;
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            last_idx <= '0;
            loc_q    <= '0;
            val_q    <= '0;
            applied  <= '0;
            result_q <= RES_CLEAN;
            count_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start && (erased || syn_zero)) begin
                        result_q <= RES_CLEAN;
                        count_q  <= '0;
                    end
                end
                S_WAIT: begin
                    if (cls == CLS_CLEAN) begin
                        result_q <= RES_CLEAN;
                        count_q  <= '0;
                    end else if (cls == CLS_FAIL) begin
                        result_q <= RES_FAIL;
                        count_q  <= '0;
                    end else if (cls == CLS_APPLY) begin
                        loc_q    <= loc_words;
                        val_q    <= val_words;
                        last_idx <= err_cnt;
                        idx      <= '0;
                        applied  <= '0;
                    end
                end
                S_READ: begin
                    if (!in_range[idx]) begin
                        if (is_last) begin
                            result_q <= RES_FIXED;
                            count_q  <= applied;
                        end else begin
                            idx <= CNT_W'(idx + 1'b1);
                        end
                    end
                end
                S_WRITE: begin
                    applied <= FIXC_W'(applied + 1'b1);
                    if (is_last) begin
                        result_q <= RES_FIXED;
                        count_q  <= FIXC_W'(applied + 1'b1);
                    end else begin
                        idx <= CNT_W'(idx + 1'b1);
                    end
                end
                S_FINISH: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_FINISH);
        ram_addr  = offs[idx];
        ram_we    = (state == S_WRITE);
        ram_wdata = ram_rdata ^ vals[idx];
        result    = result_q;
        fix_count = count_q;
    end

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ($past(state) == S_READ) && ($past(ram_addr) == ram_addr)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_FAIL_NO_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (result == RES_FAIL)) |-> (fix_count == '0)); // R6

    AST_FIX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (result == RES_FIXED)) |-> (fix_count <= FIXC_W'(last_idx) + 1'b1)); // R7

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R11

    AST_NO_WRITE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT) |-> !ram_we); // R4

endmodule

// File: tb/test_ecc_fix_applier.sv
module test_ecc_fix_applier;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [79:0]  stored_ecc = '0;
    logic [127:0] syndrome = '0;
    logic [3:0]   corr_state = 4'h9;
    logic [1:0]   err_cnt = '0;
    logic [63:0]  loc_words = '0;
    logic [63:0]  val_words = '0;
    logic [8:0]   ram_addr;
    logic         ram_we;
    logic [7:0]   ram_wdata;
    logic [7:0]   ram_rdata;
    logic         busy, done;
    logic [1:0]   result;
    logic [2:0]   fix_count;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    int wr_seen  = 0;

    logic [7:0] mem  [512];
    logic [7:0] gold [512];

    always #2 clk = ~clk;

    ecc_fix_applier i_ecc_fix_applier (
        .clk(clk), .rst_n(rst_n), .start(start), .stored_ecc(stored_ecc),
        .syndrome(syndrome), .corr_state(corr_state), .err_cnt(err_cnt),
        .loc_words(loc_words), .val_words(val_words), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .busy(busy), .done(done), .result(result), .fix_count(fix_count)
    );

    always @(posedge clk) begin
        if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
            wr_seen <= wr_seen + 1;
        end
        ram_rdata <= mem[ram_addr];
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_mem(input string tag);
        int bad = 0;
        for (int i = 0; i < 512; i++) if (mem[i] !== gold[i]) bad++;
        check(tag, bad, 0);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic await_done(input string tag);
        int n = 0;
        while (!done && n < 200) begin
            @(negedge clk); n++;
        end
        check({tag, " done seen"}, done, 1);
    endtask

    function automatic logic [63:0] pack4(input logic [15:0] a0, a1, a2, a3);
        return {a3, a2, a1, a0};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 ram_we", ram_we, 0);
        check("R1 result", result, 0);
        check("R1 fix_count", fix_count, 0);
    endtask

    task automatic t_erased();
        int w0 = wr_seen;
        stored_ecc = {80{1'b1}};
        syndrome   = 128'h1;
        corr_state = 4'h9;
        pulse_start();
        check("R2 erased done next cycle", done, 1);
        check("R2 erased result", result, 0);
        check("R2 erased count", fix_count, 0);
        check("R2 erased no write", wr_seen - w0, 0);
        stored_ecc = '0;
        @(negedge clk);
    endtask

    task automatic t_zero_syn();
        int w0 = wr_seen;
        stored_ecc = 80'h12;
        syndrome   = '0;
        corr_state = 4'hC;
        pulse_start();
        check("R3 zero syndrome done next cycle", done, 1);
        check("R3 zero syndrome result", result, 0);
        check("R3 zero syndrome no write", wr_seen - w0, 0);
        @(negedge clk);
    endtask

    task automatic t_wait_and_clean(input logic [3:0] final_code);
        logic [3:0] pend [11] = '{4'h4, 4'h6, 4'h7, 4'h8, 4'h9, 4'hA,
                                   4'hB, 4'hC, 4'hD, 4'hE, 4'hF};
        int stuck = 0;
        int w0 = wr_seen;
        stored_ecc = 80'h55;
        syndrome   = 128'h80;
        corr_state = 4'hE;
        pulse_start();
        for (int k = 0; k < 11; k++) begin
            corr_state = pend[k];
            @(negedge clk);
            if (!busy || done) stuck++;
        end
        check("R4 pending codes keep waiting", stuck, 0);
        corr_state = final_code;
        await_done("R5 clean code");
        check("R5 clean result", result, 0);
        check("R5 clean count", fix_count, 0);
        check("R5 clean no write", wr_seen - w0, 0);
        check_mem("R5 sector unchanged");
        @(negedge clk);
    endtask

    task automatic t_too_many();
        int w0 = wr_seen;
        stored_ecc = 80'h55;
        syndrome   = 128'h3;
        corr_state = 4'h1;
        err_cnt    = 2'd3;
        loc_words  = pack4(16'd100, 16'd200, 16'd300, 16'd400);
        val_words  = 64'hFFFF_FFFF_FFFF_FFFF;
        pulse_start();
        await_done("R6 fail");
        check("R6 uncorrectable result", result, 2);
        check("R6 uncorrectable count", fix_count, 0);
        check("R6 no write", wr_seen - w0, 0);
        check_mem("R6 sector unchanged");
        @(negedge clk);
    endtask

    task automatic fix_case(input string tag, input logic [3:0] code, input logic [1:0] cnt,
                            input logic [63:0] locs, input logic [63:0] vls);
        int w0 = wr_seen;
        int applied = 0;
        for (int k = 0; k <= cnt; k++) begin
            int loc = int'(locs[32*(k/2) + 16*(k%2) +: 10]);
            int off = 519 - loc;
            if (off >= 0 && off < 512) begin
                gold[off] = gold[off] ^ vls[32*(k/2) + 16*(k%2) +: 8];
                applied++;
            end
        end
        stored_ecc = 80'hA0;
        syndrome   = 128'h1 << 77;
        corr_state = code;
        err_cnt    = cnt;
        loc_words  = locs;
        val_words  = vls;
        pulse_start();
        await_done(tag);
        check({tag, " R10 result corrected"}, result, 1);
        check({tag, " R10 fix_count"}, fix_count, applied);
        check({tag, " R9 write count"}, wr_seen - w0, applied);
        check_mem({tag, " R7 R8 sector contents"});
        @(negedge clk);
        check({tag, " R10 result held"}, result, 1);
    endtask

    task automatic t_busy_start();
        stored_ecc = 80'h77;
        syndrome   = 128'h9;
        corr_state = 4'hB;
        pulse_start();
        stored_ecc = {80{1'b1}};
        pulse_start();
        @(negedge clk);
        check("R11 start while busy ignored (busy)", busy, 1);
        check("R11 start while busy ignored (no done)", done, 0);
        stored_ecc = 80'h77;
        gold[519 - 50] = gold[519 - 50] ^ 8'h42;
        err_cnt   = 2'd0;
        loc_words = pack4(16'd50, 16'd0, 16'd0, 16'd0);
        val_words = pack4(16'h0042, 16'h0, 16'h0, 16'h0);
        corr_state = 4'h3;
        await_done("R11 completion");
        check("R11 result", result, 1);
        check("R11 count", fix_count, 1);
        check_mem("R11 sector");
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i]  = 8'(i * 7 + 3);
            gold[i] = 8'(i * 7 + 3);
        end
        t_reset();
        t_erased();
        t_zero_syn();
        t_wait_and_clean(4'h0);
        t_wait_and_clean(4'h5);
        t_too_many();
        // R7 R8: four in-range errors, junk in upper lane bits
        fix_case("R7 four errors", 4'h3, 2'd3,
                 pack4({6'h2A, 10'd519}, {6'h15, 10'd8}, {6'h3F, 10'd263}, {6'h01, 10'd100}),
                 pack4(16'hC3A5, 16'h7E3C, 16'h11FF, 16'hEE01));
        // R8: out-of-range locations skipped, parity-completion code
        fix_case("R8 range edges", 4'h2, 2'd3,
                 pack4(16'd520, 16'd7, 16'd1023, 16'd300),
                 pack4(16'h0011, 16'h0022, 16'h0033, 16'h0080));
        // R7: only slot 0 used when err_cnt is 0
        fix_case("R7 single slot", 4'h3, 2'd0,
                 pack4(16'd10, 16'd11, 16'd12, 16'd13),
                 pack4(16'h0005, 16'h0006, 16'h0007, 16'h0008));
        // R9: two errors on one byte
        fix_case("R9 same byte", 4'h3, 2'd1,
                 pack4(16'd400, 16'd400, 16'd0, 16'd0),
                 pack4(16'h000F, 16'h00F0, 16'h0, 16'h0));
        // R10: all skipped, count zero
        fix_case("R10 none applied", 4'h2, 2'd1,
                 pack4(16'd0, 16'd1, 16'd0, 16'd0),
                 pack4(16'h00AA, 16'h00BB, 16'h0, 16'h0));
        t_busy_start();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule